// File: doc/BRIEF.md
# Condition register masked field writer

This block holds a 32-bit condition register built from eight 4-bit fields and carries out the move-to-condition-register-fields operation. On each issue strobe it decodes a 32-bit instruction word. If the primary and extended opcodes match, it takes an 8-bit field mask from the word. Each field whose mask bit is set is loaded from the matching nibble of the low 32 bits of a 64-bit source operand. Every other field keeps its value.

The whole register is always visible on a read port. A recognised flag reports, one cycle after the issue, whether the issued word was this operation. Both the full-register form (all mask bits set) and the single-field form (marker bit set, one mask bit set) run through the same masked update. The block touches no other status.

Top module: `cr_field_writer`

## Requirements
- R1: A synchronous active-low reset clears all eight fields (cr_o = 0) and deasserts hit_o.
- R2: The word is recognised only when insn_i[31:26] = 31 and insn_i[10:1] = 144 (base word 0x7C000120). An issue of a recognised word raises hit_o for exactly the following cycle.
- R3: An issue whose opcodes do not match leaves cr_o unchanged, and hit_o is low in the following cycle.
- R4: The mask is insn_i[19:12], read MSB-first. Mask bit insn_i[19-i] selects field i. Field i is cr_o[31-4i:28-4i] and is loaded from src_i[31-4i:28-4i], so field 0 takes src_i[31:28] and field 7 takes src_i[3:0].
- R5: A field whose mask bit is clear keeps its previous value, including when the whole mask is zero.
- R6: src_i[63:32] has no effect on the register.
- R7: A mask of 0xFF loads the whole register from src_i[31:0].
- R8: The single-field marker insn_i[20] does not change the result. The same masked update applies to whatever mask bits are set. The source number field insn_i[25:21] is also ignored.
- R9: The update is taken on the clock edge that samples issue_i and is visible on cr_o from the next cycle. With issue_i low, the register and hit_o do not change (hit_o stays low).
- R10: A mask of 0x38 updates fields 2, 3 and 4 only and keeps fields 0, 1, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | Instruction issue strobe |
| insn_i | input | 32 | Instruction word |
| src_i | input | 64 | Source operand value |
| cr_o | output | 32 | Whole condition register (read port) |
| hit_o | output | 1 | Previous cycle's issue was recognised |

## Verification
The bench builds the block with its default parameters: eight fields of four bits. This puts every single-field mask position within reach, along with the all-ones and all-zero masks and the 0x38 save/restore pattern. A sequence of pseudo-random masks covers mixed patterns. Sources carry distinct patterns in their upper words, so any leak from src_i[63:32] shows up in the result. Near-miss opcodes (primary 30, extended 145 and 339) and issues made with the strobe low confirm that nothing else writes the register.

// File: rtl/cr_pkg.sv
// Package: shared constants for the condition register field writer.
// Assumes the 32-bit instruction layout with LSB-0 bit numbering.
package cr_pkg;
    localparam int          INSN_W      = 32;
    localparam logic [5:0]  OPC_PRIMARY = 6'd31;
    localparam logic [9:0]  OPC_EXT     = 10'd144;
    localparam int          PRIM_LSB    = 26;
    localparam int          EXT_LSB     = 1;
    localparam int          MASK_LSB    = 12;
endpackage

// File: rtl/cr_decode.sv
// Module: cr_decode
// Recognises the masked-field move and extracts its field mask.
// Assumes mask bits sit at MASK_LSB upward; the marker, source number
// and reserved bits are deliberately ignored.
module cr_decode
    import cr_pkg::*;
#(
    parameter int NFIELDS = 8
) (
    input  logic [INSN_W-1:0]  insn,
    output logic               match,
    output logic [NFIELDS-1:0] mask
);
    localparam int MASK_MSB = MASK_LSB + NFIELDS - 1;

    logic unused_insn_bits;

    // Purpose: compare the primary and extended opcode fields.
    always_comb begin
        match = (insn[PRIM_LSB +: 6] == OPC_PRIMARY) &&
                (insn[EXT_LSB +: 10] == OPC_EXT);
    end

    // Purpose: pass the field mask through, MSB = field 0.
    assign mask = insn[MASK_MSB:MASK_LSB];

    assign unused_insn_bits = ^{insn[PRIM_LSB-1:MASK_MSB+1],
                                insn[MASK_LSB-1:EXT_LSB+10], insn[0]};
endmodule

// File: rtl/cr_merge.sv
// Module: cr_merge
// Per-field select between the current register and new data.
// Assumes mask[NFIELDS-1] selects field 0, which sits in the top nibble.
module cr_merge #(
    parameter int NFIELDS = 8,
    parameter int FW      = 4
) (
    input  logic [NFIELDS*FW-1:0] cur,
    input  logic [NFIELDS*FW-1:0] data,
    input  logic [NFIELDS-1:0]    mask,
    output logic [NFIELDS*FW-1:0] nxt
);
    localparam int CRW = NFIELDS * FW;

    for (genvar i = 0; i < NFIELDS; i++) begin : g_field
        localparam int HI = CRW - 1 - i * FW;
        // Purpose: choose new or old nibble for field i.
        assign nxt[HI -: FW] = mask[NFIELDS-1-i] ? data[HI -: FW] : cur[HI -: FW];
    end

    // Purpose: an empty mask must give back the current value (R5).
    always_comb begin
        if (mask == '0) begin
            assert_empty_mask_keeps_R5: assert (nxt == cur);
        end
    end
endmodule

// File: rtl/cr_field_writer.sv
// Module: cr_field_writer (top)
// Condition register of NFIELDS fields with a masked move-in operation.
// Assumes NFIELDS*FW does not exceed SRC_W; upper source bits are unused.
module cr_field_writer
    import cr_pkg::*;
#(
    parameter int NFIELDS = 8,
    parameter int FW      = 4,
    parameter int SRC_W   = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue_i,
    input  logic [INSN_W-1:0]     insn_i,
    input  logic [SRC_W-1:0]      src_i,
    output logic [NFIELDS*FW-1:0] cr_o,
    output logic                  hit_o
);
    localparam int CRW = NFIELDS * FW;

    logic               match;
    logic [NFIELDS-1:0] mask;
    logic [CRW-1:0]     cr_q;
    logic [CRW-1:0]     cr_nxt;
    logic               hit_q;
    logic               do_write;
    logic               unused_src_hi;

    cr_decode #(.NFIELDS(NFIELDS)) u_decode (
        .insn  (insn_i),
        .match (match),
        .mask  (mask)
    );

    cr_merge #(.NFIELDS(NFIELDS), .FW(FW)) u_merge (
        .cur  (cr_q),
        .data (src_i[CRW-1:0]),
        .mask (mask),
        .nxt  (cr_nxt)
    );

    assign do_write      = issue_i & match;
    assign unused_src_hi = ^src_i[SRC_W-1:CRW];

    // Purpose: hold the register and the recognised flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q  <= '0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= do_write;
            if (do_write) cr_q <= cr_nxt;
        end
    end

    assign cr_o  = cr_q;
    assign hit_o = hit_q;

    // Reset leaves an all-zero register and a low flag (R1).
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cr_q == '0 && !hit_q));

    // The flag only follows a strobed issue (R2).
    assert_hit_needs_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> $past(issue_i));

    // A mismatched issue changes nothing (R3).
    assert_miss_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !match) |=> ($stable(cr_q) && !hit_q));

    // No strobe, no change (R9).
    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> ($stable(cr_q) && !hit_q));

    // A full mask loads the low source word (R7).
    assert_full_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && match && mask == '1) |=> (cr_q == $past(src_i[CRW-1:0])));
endmodule

// File: tb/test_cr_field_writer.sv
// Scoreboard bench for cr_field_writer: a driver pushes expected
// results, a monitor pops and compares one item per cycle.
module test_cr_field_writer;
    typedef struct {
        logic [31:0] cr;
        logic        hit;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] src = '0;
    logic [31:0] cr_o;
    logic        hit_o;

    exp_t        sb_q[$];
    logic [31:0] model_cr = '0;
    int          errs = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cr_field_writer i_cr_field_writer (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .insn_i(insn),
        .src_i(src), .cr_o(cr_o), .hit_o(hit_o)
    );

    function automatic logic [31:0] mk(input logic [5:0] prim, input logic [9:0] ext,
                                       input logic [7:0] m, input logic marker);
        return {prim, 5'd12, marker, m, 1'b0, ext, 1'b0};
    endfunction

    // Driver: one cycle of stimulus plus its expected result.
    task automatic step(input logic rst, input logic iss, input logic [31:0] w,
                        input logic [63:0] s, input string tag);
        exp_t e;
        logic rec;
        @(negedge clk);
        rst_n = rst; issue = iss; insn = w; src = s;
        rec = (w[31:26] == 6'd31) && (w[10:1] == 10'd144);
        if (!rst) begin
            model_cr = '0;
            e.hit = 1'b0;
        end else begin
            e.hit = iss && rec;
            if (iss && rec)
                for (int f = 0; f < 8; f++)
                    if (w[19-f]) model_cr[31-4*f -: 4] = s[31-4*f -: 4];
        end
        e.cr = model_cr;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after each active edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (cr_o !== e.cr || hit_o !== e.hit) begin
                    errs++;
                    $display("FAIL %s: cr=%h hit=%b expected cr=%h hit=%b",
                             e.tag, cr_o, hit_o, e.cr, e.hit);
                end
            end
        end
    end

    initial begin
        logic [7:0] lfsr;
        step(0, 0, '0, '0, "R1 reset");
        step(0, 1, mk(31, 144, 8'hFF, 0), 64'h1111_1111_2222_2222, "R1 reset wins");
        step(1, 0, '0, '0, "R9 idle after reset");
        step(1, 1, mk(31, 144, 8'hFF, 0), 64'hDEAD_BEEF_1234_5678, "R7 full load, R6 upper");
        step(1, 0, mk(31, 144, 8'hFF, 0), 64'hFFFF_FFFF_FFFF_FFFF, "R9 strobe low");
        step(1, 1, mk(31, 144, 8'h38, 0), 64'h0000_0000_ABCD_EF01, "R10 mask 38");
        step(1, 1, mk(31, 144, 8'h00, 0), 64'h0000_0000_FFFF_FFFF, "R5 empty mask");
        step(1, 1, mk(30, 144, 8'hFF, 0), 64'h0, "R3 wrong primary");
        step(1, 1, mk(31, 145, 8'hFF, 0), 64'h0, "R3 wrong extended");
        step(1, 1, mk(31, 339, 8'hFF, 0), 64'h0, "R3 other extended");
        step(1, 1, mk(31, 144, 8'hFF, 0), 64'h5A5A_5A5A_0000_0000, "R6 R7 zero low word");
        for (int f = 0; f < 8; f++)
            step(1, 1, mk(31, 144, 8'h80 >> f, 1), 64'hCAFE_0000_0000_0000 | (64'hF << (28 - 4*f)),
                 "R4 R8 single field");
        step(1, 1, mk(31, 144, 8'hC3, 1), 64'h0000_0000_0123_4567, "R8 marker multi");
        lfsr = 8'h5B;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(1, 1, mk(31, 144, lfsr, lfsr[0]),
                 {24'hA5A5A5, lfsr, 8'h00, lfsr, ~lfsr, lfsr ^ 8'h3C}, "R5 R4 mixed masks");
            if (k % 7 == 0) step(1, 0, '0, '1, "R9 idle gap");
        end
        step(0, 0, '0, '0, "R1 mid reset");
        step(1, 1, mk(31, 144, 8'h01, 0), 64'h0000_0000_0000_0009, "R4 field 7 low nibble");
        step(1, 1, mk(31, 144, 8'h80, 0), 64'h0000_0000_7000_0000, "R4 field 0 top nibble");
        step(1, 0, '0, '0, "R2 flag one cycle");
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            errs++;
            checks++;
            $display("FAIL R2: %0d results missing, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule